// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block interprets the bus write cycles that a host issues to a banked NOR-style flash memory. Each write carries an address and a data word. The decoder follows the multi-write unlock and command sequences. When a sequence completes it raises a single-cycle strobe for a read reset, a program, a chip erase, a sector erase, a suspend, a resume, an identifier query, a parameter query or a configuration write. With each strobe it captures the address and data fields that the operation needs.

The block also keeps the state that decides how later writes are read: the read mode (array, identifier or parameter query), a fast-command mode in which program and chip erase need only two writes, a busy flag for the embedded operation, and a flag that marks a sector erase as suspended. The embedded algorithm itself is outside the block. A `op_done` pulse ends the current operation.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset every strobe is 0, `read_mode` is 0 (array), and `busy`, `bypass_on` and `erase_suspended` are 0. All captured fields are 0.
- R2: The writes AA@555, 55@2AA and A0@555, followed by any write, pulse `stb_program` for one cycle. The strobe comes in the cycle after that last write. The same edge captures the last write's address in `prog_addr` and its data in `prog_data`, and sets `busy`.
- R3: Matching of unlock and command writes looks only at address bits 11:0 and data bits 7:0. The other bits are ignored.
- R4: After the unlock pair, 80@555, and a second unlock pair, the write 10@555 pulses `stb_chip_erase`. In the same position, 30 at any address pulses `stb_sector_erase` and captures the top SECT_W address bits in `sector_sel`. Both set `busy`.
- R5: A write that does not match the next step of a sequence drops the partial sequence with no strobe. Matching then restarts from the first unlock write.
- R6: After the unlock pair, 90@555 pulses `stb_ident`, sets `read_mode` to 1 and captures the top BANK_W address bits in `bank_sel`. F0 at any address outside a data step pulses `stb_read_reset` and sets `read_mode` to 0.
- R7: A single write of 98 with address bits 11:0 equal to 055 pulses `stb_query` and sets `read_mode` to 2. A write of 98 at any other address does nothing when fast-command mode is off.
- R8: The unlock pair followed by 20@555 sets `bypass_on`. While it is set, these sequences work at any address: A0 then any write is a program, 80 then 10 is a chip erase, a single 98 is a query, and 90 then 00 clears `bypass_on`.
- R9: While `busy` is 1, every write other than F0 and B0 has no effect on strobes, modes or captured fields. A partial sequence is dropped. A pulse on `op_done` clears `busy`.
- R10: B0 at any address while a sector erase is busy pulses `stb_suspend`, clears `busy`, sets `erase_suspended` and captures `bank_sel`. At other times B0 is ignored. While the erase is suspended and the block is not busy, 30 at any address pulses `stb_resume`, sets `busy` again, clears `erase_suspended` and captures `bank_sel`.
- R11: While `erase_suspended` is 1, a program still runs. Chip erase, sector erase and configuration writes complete their sequence but give no strobe. F0 leaves `erase_suspended` set.
- R12: The unlock pair, D0@555 and any further write pulse `stb_cfg_write`, capture that write's data in `cfg_data` and set `busy`.
- R13: No two strobes are high in the same cycle. Each strobe lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | A bus write is present this cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| op_done | input | 1 | Pulse: embedded operation finished |
| stb_read_reset | output | 1 | Read-reset strobe |
| stb_program | output | 1 | Program strobe |
| stb_chip_erase | output | 1 | Chip erase strobe |
| stb_sector_erase | output | 1 | Sector erase strobe |
| stb_suspend | output | 1 | Erase suspend strobe |
| stb_resume | output | 1 | Erase resume strobe |
| stb_ident | output | 1 | Identifier query strobe |
| stb_query | output | 1 | Parameter query strobe |
| stb_cfg_write | output | 1 | Configuration write strobe |
| prog_addr | output | ADDR_W | Captured program address |
| prog_data | output | DATA_W | Captured program data |
| sector_sel | output | SECT_W | Captured sector of the last sector erase |
| bank_sel | output | BANK_W | Captured bank of the last identifier, suspend or resume |
| cfg_data | output | DATA_W | Captured configuration word |
| read_mode | output | 2 | 0 array, 1 identifier, 2 parameter query |
| bypass_on | output | 1 | Fast-command mode active |
| busy | output | 1 | Embedded operation running |
| erase_suspended | output | 1 | A sector erase is suspended |

## Verification
Every result of a write is registered once. Strobes, captured fields and mode flags therefore all change on the first rising edge that samples the write. The bench applies each write on a falling edge and removes it on the next falling edge. It compares all outputs at that second falling edge, where a strobe for that write must be high and must not yet have gone low. An `op_done` pulse is checked the same way: `busy` must be low one edge later. Random command traffic, including writes made while the block is busy and stray data, is compared after every single write against a reference model driven by the same writes.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  localparam int UNLK_W = 12;

  localparam logic [UNLK_W-1:0] A_FIRST  = 12'h555;
  localparam logic [UNLK_W-1:0] A_SECOND = 12'h2AA;
  localparam logic [UNLK_W-1:0] A_QUERY  = 12'h055;

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_U1, SQ_U2, SQ_PRG, SQ_CFG, SQ_ERS, SQ_EU1, SQ_EU2,
    SQ_BP_PRG, SQ_BP_ERS, SQ_BP_RST
  } seq_e;

  typedef enum logic [1:0] {
    RM_ARRAY = 2'd0,
    RM_IDENT = 2'd1,
    RM_QUERY = 2'd2
  } rdmode_e;

  typedef struct packed {
    logic a_first, a_second, a_query;
    logic d_aa, d_55, d_90, d_a0, d_80, d_20, d_d0, d_10, d_30, d_f0, d_b0, d_98, d_00;
  } hit_t;

  typedef struct packed {
    logic rst, prog, chip, sect, susp, resm, ident, query, cfg, byp_on, byp_off;
  } req_t;

endpackage

// File: rtl/fcd_match.sv
module fcd_match
  import fcd_pkg::*;
(
  input  logic [UNLK_W-1:0] addr_lo,
  input  logic [7:0]        data_lo,
  output hit_t              hit
);

  always_comb begin
    hit          = '0;
    hit.a_first  = (addr_lo == A_FIRST);
    hit.a_second = (addr_lo == A_SECOND);
    hit.a_query  = (addr_lo == A_QUERY);
    hit.d_aa     = (data_lo == 8'hAA);
    hit.d_55     = (data_lo == 8'h55);
    hit.d_90     = (data_lo == 8'h90);
    hit.d_a0     = (data_lo == 8'hA0);
    hit.d_80     = (data_lo == 8'h80);
    hit.d_20     = (data_lo == 8'h20);
    hit.d_d0     = (data_lo == 8'hD0);
    hit.d_10     = (data_lo == 8'h10);
    hit.d_30     = (data_lo == 8'h30);
    hit.d_f0     = (data_lo == 8'hF0);
    hit.d_b0     = (data_lo == 8'hB0);
    hit.d_98     = (data_lo == 8'h98);
    hit.d_00     = (data_lo == 8'h00);
  end

endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  hit_t hit,
  input  logic busy_i,
  input  logic sect_i,
  input  logic susp_i,
  input  logic byp_i,
  input  logic done_i,
  output req_t req_o
);

  seq_e st_q, st_d;
  logic data_st;

  assign data_st = (st_q == SQ_PRG) || (st_q == SQ_CFG) || (st_q == SQ_BP_PRG);

  always_comb begin
    st_d  = st_q;
    req_o = '0;
    if (wr_en) begin
      st_d = SQ_IDLE;
      if (busy_i) begin
        if (hit.d_f0)                             req_o.rst  = 1'b1;
        else if (hit.d_b0 && sect_i && !done_i)   req_o.susp = 1'b1;
      end else if (!data_st && hit.d_f0) begin
        req_o.rst = 1'b1;
      end else begin
        unique case (st_q)
          SQ_IDLE: begin
            if (hit.d_30 && susp_i)            req_o.resm = 1'b1;
            else if (byp_i) begin
              if (hit.d_a0)                    st_d = SQ_BP_PRG;
              else if (hit.d_80)               st_d = SQ_BP_ERS;
              else if (hit.d_90)               st_d = SQ_BP_RST;
              else if (hit.d_98)               req_o.query = 1'b1;
            end
            else if (hit.d_98 && hit.a_query)  req_o.query = 1'b1;
            else if (hit.d_aa && hit.a_first)  st_d = SQ_U1;
          end
          SQ_U1:  if (hit.d_55 && hit.a_second) st_d = SQ_U2;
          SQ_U2: begin
            if (hit.a_first) begin
              if (hit.d_90)      req_o.ident  = 1'b1;
              else if (hit.d_a0) st_d         = SQ_PRG;
              else if (hit.d_80) st_d         = SQ_ERS;
              else if (hit.d_20) req_o.byp_on = 1'b1;
              else if (hit.d_d0) st_d         = SQ_CFG;
            end
          end
          SQ_ERS: if (hit.d_aa && hit.a_first)  st_d = SQ_EU1;
          SQ_EU1: if (hit.d_55 && hit.a_second) st_d = SQ_EU2;
          SQ_EU2: begin
            if (hit.d_10 && hit.a_first) req_o.chip = !susp_i;
            else if (hit.d_30)           req_o.sect = !susp_i;
          end
          SQ_PRG, SQ_BP_PRG: req_o.prog = 1'b1;
          SQ_CFG:    req_o.cfg     = !susp_i;
          SQ_BP_ERS: req_o.chip    = hit.d_10 && !susp_i;
          SQ_BP_RST: req_o.byp_off = hit.d_00;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end

  // R8: the two-write states are reachable only in fast-command mode
  assert_bypass_states_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_BP_PRG || st_q == SQ_BP_ERS || st_q == SQ_BP_RST) |-> byp_i);

  // R9: a write taken while busy leaves no partial sequence
  assert_busy_drops_seq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy_i) |=> (st_q == SQ_IDLE));

endmodule

// File: rtl/fcd_mode.sv
module fcd_mode
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int SECT_W = 8,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  req_t              req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              op_done,
  output logic [8:0]        stb_o,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic [SECT_W-1:0] sector_sel,
  output logic [BANK_W-1:0] bank_sel,
  output logic [DATA_W-1:0] cfg_data,
  output rdmode_e           rd_mode,
  output logic              byp_q,
  output logic              busy_q,
  output logic              sect_q,
  output logic              susp_q
);

  rdmode_e rm_d;
  logic    byp_d, busy_d, sect_d, susp_d;
  logic [8:0] stb_d;
  logic    en_prog, en_sect, en_bank, en_cfg;

  assign stb_d   = {req.rst, req.prog, req.chip, req.sect, req.susp,
                    req.resm, req.ident, req.query, req.cfg};
  assign en_prog = req.prog;
  assign en_sect = req.sect;
  assign en_bank = req.ident | req.susp | req.resm;
  assign en_cfg  = req.cfg;

  always_comb begin
    rm_d   = rd_mode;
    byp_d  = byp_q;
    busy_d = busy_q;
    sect_d = sect_q;
    susp_d = susp_q;
    if (req.rst)   rm_d = RM_ARRAY;
    if (req.ident) rm_d = RM_IDENT;
    if (req.query) rm_d = RM_QUERY;
    if (busy_q && op_done) begin
      busy_d = 1'b0;
      sect_d = 1'b0;
    end
    if (req.prog || req.chip || req.cfg) begin
      busy_d = 1'b1;
      sect_d = 1'b0;
    end
    if (req.sect || req.resm) begin
      busy_d = 1'b1;
      sect_d = 1'b1;
    end
    if (req.resm) susp_d = 1'b0;
    if (req.susp) begin
      busy_d = 1'b0;
      susp_d = 1'b1;
    end
    if (req.byp_on)  byp_d = 1'b1;
    if (req.byp_off) byp_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_o   <= '0;
      rd_mode <= RM_ARRAY;
      byp_q   <= 1'b0;
      busy_q  <= 1'b0;
      sect_q  <= 1'b0;
      susp_q  <= 1'b0;
    end else begin
      stb_o   <= stb_d;
      rd_mode <= rm_d;
      byp_q   <= byp_d;
      busy_q  <= busy_d;
      sect_q  <= sect_d;
      susp_q  <= susp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_addr  <= '0;
      prog_data  <= '0;
      sector_sel <= '0;
      bank_sel   <= '0;
      cfg_data   <= '0;
    end else begin
      if (en_prog) begin
        prog_addr <= wr_addr;
        prog_data <= wr_data;
      end
      if (en_sect) sector_sel <= wr_addr[ADDR_W-1 -: SECT_W];
      if (en_bank) bank_sel   <= wr_addr[ADDR_W-1 -: BANK_W];
      if (en_cfg)  cfg_data   <= wr_data;
    end
  end

  assert_one_strobe_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb_o));

  assert_suspend_needs_sector_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stb_o[4] |-> $past(busy_q && sect_q));

  assert_cfg_not_suspended_R12: assert property (@(posedge clk) disable iff (!rst_n)
    stb_o[0] |-> (!$past(susp_q) && !$past(busy_q)));

  assert_busy_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (stb_o[7] || stb_o[6] || stb_o[5] || stb_o[3] || stb_o[0]));

  assert_done_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && op_done) |=> !busy_q);

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int SECT_W = 8,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              op_done,
  output logic              stb_read_reset,
  output logic              stb_program,
  output logic              stb_chip_erase,
  output logic              stb_sector_erase,
  output logic              stb_suspend,
  output logic              stb_resume,
  output logic              stb_ident,
  output logic              stb_query,
  output logic              stb_cfg_write,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic [SECT_W-1:0] sector_sel,
  output logic [BANK_W-1:0] bank_sel,
  output logic [DATA_W-1:0] cfg_data,
  output logic [1:0]        read_mode,
  output logic              bypass_on,
  output logic              busy,
  output logic              erase_suspended
);

  logic    [1:0] rst_sync;
  logic          rst_s_n;
  hit_t          hit;
  req_t          req;
  logic    [8:0] stb;
  rdmode_e       rm;
  logic          sect_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s_n = rst_sync[1];

  fcd_match u_match (
    .addr_lo (wr_addr[UNLK_W-1:0]),
    .data_lo (wr_data[7:0]),
    .hit     (hit)
  );

  fcd_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .wr_en  (wr_en),
    .hit    (hit),
    .busy_i (busy),
    .sect_i (sect_busy),
    .susp_i (erase_suspended),
    .byp_i  (bypass_on),
    .done_i (op_done),
    .req_o  (req)
  );

  fcd_mode #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SECT_W (SECT_W),
    .BANK_W (BANK_W)
  ) u_mode (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .req        (req),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .op_done    (op_done),
    .stb_o      (stb),
    .prog_addr  (prog_addr),
    .prog_data  (prog_data),
    .sector_sel (sector_sel),
    .bank_sel   (bank_sel),
    .cfg_data   (cfg_data),
    .rd_mode    (rm),
    .byp_q      (bypass_on),
    .busy_q     (busy),
    .sect_q     (sect_busy),
    .susp_q     (erase_suspended)
  );

  assign {stb_read_reset, stb_program, stb_chip_erase, stb_sector_erase, stb_suspend,
          stb_resume, stb_ident, stb_query, stb_cfg_write} = stb;
  assign read_mode = rm;

endmodule

// File: tb/tb_flash_cmd_decoder.sv
module tb_flash_cmd_decoder;

  localparam int AW = 20;
  localparam int DW = 16;
  localparam int SW = 8;
  localparam int BW = 2;

  logic clk, rst_n, wr_en, op_done;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic s_rst, s_prog, s_chip, s_sect, s_susp, s_resm, s_id, s_qry, s_cfg;
  logic [AW-1:0] prog_addr;
  logic [DW-1:0] prog_data, cfg_data;
  logic [SW-1:0] sector_sel;
  logic [BW-1:0] bank_sel;
  logic [1:0]    read_mode;
  logic bypass_on, busy, erase_suspended;

  flash_cmd_decoder #(.ADDR_W(AW), .DATA_W(DW), .SECT_W(SW), .BANK_W(BW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .op_done(op_done),
    .stb_read_reset(s_rst), .stb_program(s_prog), .stb_chip_erase(s_chip),
    .stb_sector_erase(s_sect), .stb_suspend(s_susp), .stb_resume(s_resm),
    .stb_ident(s_id), .stb_query(s_qry), .stb_cfg_write(s_cfg),
    .prog_addr(prog_addr), .prog_data(prog_data), .sector_sel(sector_sel),
    .bank_sel(bank_sel), .cfg_data(cfg_data), .read_mode(read_mode),
    .bypass_on(bypass_on), .busy(busy), .erase_suspended(erase_suspended)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  string tag = "R1";

  // reference model state
  int m_seq;
  logic m_busy, m_sect, m_susp, m_byp;
  logic [1:0] m_rm;
  logic [AW-1:0] m_paddr;
  logic [DW-1:0] m_pdata, m_cfg;
  logic [SW-1:0] m_sector;
  logic [BW-1:0] m_bank;
  logic [8:0] m_stb;

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all();
    chk("strobes", {23'd0, s_rst, s_prog, s_chip, s_sect, s_susp, s_resm, s_id, s_qry, s_cfg},
        {23'd0, m_stb});
    chk("read_mode", {30'd0, read_mode}, {30'd0, m_rm});
    chk("busy", {31'd0, busy}, {31'd0, m_busy});
    chk("bypass", {31'd0, bypass_on}, {31'd0, m_byp});
    chk("suspended", {31'd0, erase_suspended}, {31'd0, m_susp});
    chk("prog_addr", {12'd0, prog_addr}, {12'd0, m_paddr});
    chk("prog_data", {16'd0, prog_data}, {16'd0, m_pdata});
    chk("sector", {24'd0, sector_sel}, {24'd0, m_sector});
    chk("bank", {30'd0, bank_sel}, {30'd0, m_bank});
    chk("cfg_data", {16'd0, cfg_data}, {16'd0, m_cfg});
  endtask

  task automatic mdl_reset();
    m_seq = 0; m_busy = 0; m_sect = 0; m_susp = 0; m_byp = 0; m_rm = 2'd0;
    m_paddr = '0; m_pdata = '0; m_cfg = '0; m_sector = '0; m_bank = '0; m_stb = '0;
  endtask

  // strobe order: rst prog chip sect susp resm ident query cfg
  task automatic mdl_wr(logic [AW-1:0] a, logic [DW-1:0] d);
    logic [7:0] d8 = d[7:0];
    logic [11:0] a12 = a[11:0];
    logic r_rst = 0, r_prog = 0, r_chip = 0, r_sect = 0, r_susp = 0, r_resm = 0;
    logic r_id = 0, r_qry = 0, r_cfg = 0, r_bon = 0, r_boff = 0;
    int nseq = 0;
    bit dst = (m_seq == 3) || (m_seq == 4) || (m_seq == 8);
    if (m_busy) begin
      if (d8 == 8'hF0) r_rst = 1;
      else if (d8 == 8'hB0 && m_sect) r_susp = 1;
    end else if (!dst && d8 == 8'hF0) r_rst = 1;
    else begin
      case (m_seq)
        0: if (d8 == 8'h30 && m_susp) r_resm = 1;
           else if (m_byp) begin
             if (d8 == 8'hA0) nseq = 8;
             else if (d8 == 8'h80) nseq = 9;
             else if (d8 == 8'h90) nseq = 10;
             else if (d8 == 8'h98) r_qry = 1;
           end
           else if (d8 == 8'h98 && a12 == 12'h055) r_qry = 1;
           else if (d8 == 8'hAA && a12 == 12'h555) nseq = 1;
        1: if (d8 == 8'h55 && a12 == 12'h2AA) nseq = 2;
        2: if (a12 == 12'h555) begin
             if (d8 == 8'h90) r_id = 1;
             else if (d8 == 8'hA0) nseq = 3;
             else if (d8 == 8'h80) nseq = 5;
             else if (d8 == 8'h20) r_bon = 1;
             else if (d8 == 8'hD0) nseq = 4;
           end
        5: if (d8 == 8'hAA && a12 == 12'h555) nseq = 6;
        6: if (d8 == 8'h55 && a12 == 12'h2AA) nseq = 7;
        7: if (d8 == 8'h10 && a12 == 12'h555) r_chip = !m_susp;
           else if (d8 == 8'h30) r_sect = !m_susp;
        3, 8: r_prog = 1;
        4: r_cfg = !m_susp;
        9: r_chip = (d8 == 8'h10) && !m_susp;
        10: r_boff = (d8 == 8'h00);
        default: ;
      endcase
    end
    m_seq = nseq;
    m_stb = {r_rst, r_prog, r_chip, r_sect, r_susp, r_resm, r_id, r_qry, r_cfg};
    if (r_rst) m_rm = 2'd0;
    if (r_id)  m_rm = 2'd1;
    if (r_qry) m_rm = 2'd2;
    if (r_prog || r_chip || r_cfg) begin m_busy = 1; m_sect = 0; end
    if (r_sect || r_resm) begin m_busy = 1; m_sect = 1; end
    if (r_resm) m_susp = 0;
    if (r_susp) begin m_busy = 0; m_susp = 1; end
    if (r_bon) m_byp = 1;
    if (r_boff) m_byp = 0;
    if (r_prog) begin m_paddr = a; m_pdata = d; end
    if (r_sect) m_sector = a[AW-1 -: SW];
    if (r_id || r_susp || r_resm) m_bank = a[AW-1 -: BW];
    if (r_cfg) m_cfg = d;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    mdl_wr(a, d);
    @(negedge clk);
    wr_en = 1'b0;
    check_all();
  endtask

  task automatic done_pulse();
    @(negedge clk);
    op_done = 1'b1;
    if (m_busy) begin m_busy = 0; m_sect = 0; end
    m_stb = '0;
    @(negedge clk);
    op_done = 1'b0;
    check_all();
  endtask

  function automatic logic [AW-1:0] ra(logic [11:0] lo);
    return {$urandom()} [AW-1:0] & ~20'hFFF | {8'd0, lo};
  endfunction

  function automatic logic [DW-1:0] rd(logic [7:0] lo);
    return {$urandom()} [DW-1:0] & 16'hFF00 | {8'd0, lo};
  endfunction

  task automatic unlock();
    wr(ra(12'h555), rd(8'hAA));
    wr(ra(12'h2AA), rd(8'h55));
  endtask

  task automatic random_op();
    int k = $urandom_range(0, 15);
    case (k)
      0: begin unlock(); wr(ra(12'h555), rd(8'hA0)); wr(ra($urandom()), rd($urandom())); end
      1: begin unlock(); wr(ra(12'h555), rd(8'h80)); unlock(); wr(ra(12'h555), rd(8'h10)); end
      2: begin unlock(); wr(ra(12'h555), rd(8'h80)); unlock(); wr(ra($urandom()), rd(8'h30)); end
      3: begin unlock(); wr(ra(12'h555), rd(8'h90)); end
      4: wr(ra(12'h055), rd(8'h98));
      5: wr(ra($urandom()), rd(8'hF0));
      6: begin unlock(); wr(ra(12'h555), rd(8'h20)); end
      7: begin wr(ra($urandom()), rd(8'hA0)); wr(ra($urandom()), rd($urandom())); end
      8: begin wr(ra($urandom()), rd(8'h80)); wr(ra($urandom()), rd(8'h10)); end
      9: begin wr(ra($urandom()), rd(8'h90)); wr(ra($urandom()), rd(8'h00)); end
      10: wr(ra($urandom()), rd(8'hB0));
      11: wr(ra($urandom()), rd(8'h30));
      12: begin unlock(); wr(ra(12'h555), rd(8'hD0)); wr(ra($urandom()), rd($urandom())); end
      13: wr(ra($urandom()), rd($urandom()));
      default: done_pulse();
    endcase
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    wr_en = 0; op_done = 0; wr_addr = '0; wr_data = '0; rst_n = 0;
    mdl_reset();
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    tag = "R1"; check_all();

    tag = "R2"; unlock(); wr(20'h3A555, 16'h00A0); wr(20'h81234, 16'hBEEF);
    chk("prog strobe R2", {31'd0, s_prog}, 32'd1);
    done_pulse();

    tag = "R3"; wr(20'hFF555, 16'h77AA); wr(20'h012AA, 16'hC355); wr(20'hA5555, 16'h11A0);
    wr(20'h00042, 16'h0042); done_pulse();

    tag = "R4"; unlock(); wr(ra(12'h555), rd(8'h80)); unlock(); wr(ra(12'h555), rd(8'h10));
    done_pulse();
    unlock(); wr(ra(12'h555), rd(8'h80)); unlock(); wr(20'hC7ABC, 16'h0030);
    chk("sector R4", {24'd0, sector_sel}, 32'hC7);
    done_pulse();

    tag = "R5"; wr(ra(12'h555), rd(8'hAA)); wr(ra(12'h2AA), rd(8'h56)); wr(ra(12'h555), rd(8'hA0));
    wr(ra(12'h2AA), rd(8'h55)); unlock(); wr(ra(12'h554), rd(8'h90));

    tag = "R6"; unlock(); wr(20'h80555, 16'h0090); wr(ra(12'h123), rd(8'hF0));

    tag = "R7"; wr(ra(12'h056), rd(8'h98)); wr(ra(12'h055), rd(8'h98)); wr(ra(12'h0), rd(8'hF0));

    tag = "R8"; unlock(); wr(ra(12'h555), rd(8'h20));
    wr(ra(12'h7), rd(8'hA0)); wr(20'h12345, 16'h5A5A); done_pulse();
    wr(ra(12'h9), rd(8'h80)); wr(ra(12'h3), rd(8'h10)); done_pulse();
    wr(ra(12'h1), rd(8'h98)); wr(ra(12'h1), rd(8'hF0));
    wr(ra(12'h4), rd(8'h90)); wr(ra(12'h4), rd(8'h00));

    tag = "R9"; unlock(); wr(ra(12'h555), rd(8'hA0)); wr(ra(12'h10), rd(8'h33));
    unlock(); wr(ra(12'h555), rd(8'hA0)); wr(ra(12'h11), rd(8'h44));
    wr(ra(12'h055), rd(8'h98)); wr(ra(12'h0), rd(8'hB0)); done_pulse();

    tag = "R10"; unlock(); wr(ra(12'h555), rd(8'h80)); unlock(); wr(ra(12'h77), rd(8'h30));
    wr(20'h40000, 16'h00B0); wr(20'hC0000, 16'h0030); wr(ra(12'h0), rd(8'hB0));

    tag = "R11"; unlock(); wr(ra(12'h555), rd(8'hA0)); wr(ra(12'h20), rd(8'h99)); done_pulse();
    unlock(); wr(ra(12'h555), rd(8'h80)); unlock(); wr(ra(12'h555), rd(8'h10));
    unlock(); wr(ra(12'h555), rd(8'hD0)); wr(ra(12'h0), rd(8'h12));
    wr(ra(12'h0), rd(8'hF0)); wr(ra(12'h0), rd(8'h30)); done_pulse();

    tag = "R12"; unlock(); wr(ra(12'h555), rd(8'hD0)); wr(ra(12'h0), 16'hA55A); done_pulse();

    tag = "R13";
    for (int i = 0; i < 600; i++) begin
      random_op();
      if (m_busy && ($urandom_range(0, 2) == 0)) done_pulse();
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule